// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Excess-One Converters

This block is a purely combinational unsigned adder. It takes two operands of `WIDTH` bits and a single carry-in. It returns a `WIDTH`-bit sum and a carry-out. The operand bits are divided into slices, and each slice is wider than the one below it, so that a slice's local addition is ready about when the carry from the slices beneath it arrives. The bottom slice is a 2-bit ripple adder that takes the external carry-in directly.

Every higher slice has only one ripple adder, which assumes that no carry comes in. It then derives the "carry came in" answer by incrementing that adder's `{carry, sum}` word. The incrementer is a converter one bit wider than the slice. A two-way selector, steered by the carry out of the slice below, chooses between the plain result and the incremented one. This removes the second ripple adder that a conventional carry-select slice would need.

The default width of 16 gives five slices of 2, 2, 3, 4 and 5 bits, from least to most significant. Wider settings keep growing the slice width by one per slice, and the top slice absorbs any bits left over. There is no clock: the outputs follow the inputs once they settle.

Top module: `csla_sqrt_adder`

## Requirements
- R1: For every operand pair and carry-in, `{cout_o, sum_o}` equals the full binary value `a_i + b_i + cin_i` computed `WIDTH+1` bits wide.
- R2: `sum_o[1:0]` equals the low two bits of `a_i[1:0] + b_i[1:0] + cin_i`, regardless of the upper operand bits.
- R3: When the bits below a slice produce a carry into that slice, the slice delivers its operand sum plus one. Without such a carry, it delivers the plain operand sum.
- R4: With both operands all ones and `cin_i = 1`, `sum_o` is all ones and `cout_o = 1`. With `a_i` all ones, `b_i = 0` and `cin_i = 1`, `sum_o` is zero and `cout_o = 1`, because every incremented slice wraps.
- R5: At the default width, slice boundaries lie at bit positions 2, 4, 7 and 11. A carry generated just below each boundary propagates correctly into the slice above it.
- R6: With both operands zero and `cin_i = 0`, `sum_o` is zero and `cout_o` is 0.
- R7: With both operands zero and `cin_i = 1`, `sum_o` is 1 and `cout_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Low `WIDTH` bits of the sum |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
Two functions can act on the same vector: a slice's own local addition, and the incoming carry that switches it to the incremented result. The hardest case is when both act together, because the local sum is all ones and the incoming carry must ripple through the incrementer into the next select. The bench provokes this with operands that are all ones below each slice boundary plus a carry-in, and with full all-ones operands. It judges the outputs against a reference addition of wider width computed in the bench. The bench also sweeps every low-slice combination under random upper bits and applies several thousand random vectors.

// File: rtl/csla_pkg.sv
package csla_pkg;

   // Number of slices: the bottom slice is 2 bits and slice g (g >= 1) is g+1 bits,
   // added while they still fit in the total width.
   function automatic int grp_count(input int width);
      int used;
      int n;
      used = 2;
      n    = 1;
      while (used + (n + 1) <= width) begin
         used = used + (n + 1);
         n    = n + 1;
      end
      return n;
   endfunction

   // Width of slice g; the top slice takes any leftover bits.
   function automatic int grp_width(input int width, input int g);
      int n;
      int base;
      int used;
      n    = grp_count(width);
      base = (g == 0) ? 2 : g + 1;
      if (g == n - 1) begin
         used = 0;
         for (int k = 0; k < n; k++) begin
            used = used + ((k == 0) ? 2 : k + 1);
         end
         base = base + (width - used);
      end
      return base;
   endfunction

   // Least significant bit position of slice g.
   function automatic int grp_lsb(input int width, input int g);
      int lsb;
      lsb = 0;
      for (int k = 0; k < g; k++) begin
         lsb = lsb + grp_width(width, k);
      end
      return lsb;
   endfunction

endpackage

// File: rtl/csla_rca.sv
module csla_rca #(
   parameter int W = 2
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   if (W < 1) begin : g_bad_width
      $error("csla_rca: W must be at least 1");
   end

   logic [W:0] chain;
   assign chain[0] = cin_i;

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic prop;
      assign prop         = a_i[i] ^ b_i[i];
      assign sum_o[i]     = prop ^ chain[i];
      assign chain[i+1]   = (a_i[i] & b_i[i]) | (chain[i] & prop);
   end

   assign cout_o = chain[W];

   logic [W:0] ref_w;
   assign ref_w = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

   always_comb begin
      AST_RCA_SUM: assert ({cout_o, sum_o} == ref_w) // R2
         else $error("ripple slice result mismatch");
   end
endmodule

// File: rtl/csla_bec.sv
module csla_bec #(
   parameter int W = 3
) (
   input  logic [W-1:0] val_i,
   output logic [W-1:0] inc_o
);
   if (W < 2) begin : g_bad_width
      $error("csla_bec: W must be at least 2");
   end

   // run[i] is high when every bit below i is one.
   logic [W-1:0] run;
   assign run[0] = 1'b1;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i > 0) begin : g_run
         assign run[i] = run[i-1] & val_i[i-1];
      end
      assign inc_o[i] = val_i[i] ^ run[i];
   end

   always_comb begin
      AST_BEC_INCREMENT: assert (inc_o == val_i + {{(W-1){1'b0}}, 1'b1}) // R4
         else $error("excess-one converter mismatch");
   end
endmodule

// File: rtl/csla_select_group.sv
module csla_select_group #(
   parameter int W = 2
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sel_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   localparam int WX = W + 1;

   logic [W-1:0]  s_zero;
   logic          c_zero;
   logic [WX-1:0] word_zero;
   logic [WX-1:0] word_one;
   logic [WX-1:0] chosen;

   csla_rca #(.W(W)) u_rca (
      .a_i   (a_i),
      .b_i   (b_i),
      .cin_i (1'b0),
      .sum_o (s_zero),
      .cout_o(c_zero)
   );

   assign word_zero = {c_zero, s_zero};

   csla_bec #(.W(WX)) u_bec (
      .val_i(word_zero),
      .inc_o(word_one)
   );

   assign chosen = sel_i ? word_one : word_zero;
   assign sum_o  = chosen[W-1:0];
   assign cout_o = chosen[W];

   logic [WX-1:0] ref_w;
   assign ref_w = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, sel_i};

   always_comb begin
      AST_SLICE_SELECT: assert ({cout_o, sum_o} == ref_w) // R3
         else $error("select slice mismatch");
   end
endmodule

// File: rtl/csla_sqrt_adder.sv
module csla_sqrt_adder #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);
   if (WIDTH < 4) begin : g_bad_width
      $error("csla_sqrt_adder: WIDTH must be at least 4");
   end

   localparam int NGRP = csla_pkg::grp_count(WIDTH);

   logic [NGRP:0] carry;
   assign carry[0] = cin_i;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int LSB = csla_pkg::grp_lsb(WIDTH, g);
      localparam int GW  = csla_pkg::grp_width(WIDTH, g);
      if (g == 0) begin : g_ripple
         csla_rca #(.W(GW)) u_rca (
            .a_i   (a_i[LSB +: GW]),
            .b_i   (b_i[LSB +: GW]),
            .cin_i (carry[g]),
            .sum_o (sum_o[LSB +: GW]),
            .cout_o(carry[g+1])
         );
      end else begin : g_select
         csla_select_group #(.W(GW)) u_sel (
            .a_i   (a_i[LSB +: GW]),
            .b_i   (b_i[LSB +: GW]),
            .sel_i (carry[g]),
            .sum_o (sum_o[LSB +: GW]),
            .cout_o(carry[g+1])
         );
      end
   end

   assign cout_o = carry[NGRP];

   logic [WIDTH:0] ref_w;
   assign ref_w = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

   always_comb begin
      AST_FULL_SUM: assert ({cout_o, sum_o} == ref_w) // R1
         else $error("adder total mismatch");
   end
endmodule

// File: tb/csla_sqrt_adder_tb.sv
module csla_sqrt_adder_tb;
   localparam int W = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [W-1:0] a, b, sum;
   logic cin, cout;
   int checks = 0;
   int errors = 0;

   csla_sqrt_adder #(.WIDTH(W)) u_dut (
      .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
   );

   task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
      @(negedge clk);
      a = av; b = bv; cin = cv;
      #5;
   endtask

   task automatic check_full(input string req);
      logic [W:0] exp_v;
      exp_v = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      checks++;
      if ({cout, sum} !== exp_v) begin
         errors++;
         $display("FAIL %s: a=%h b=%h cin=%b got=%h exp=%h", req, a, b, cin, {cout, sum}, exp_v);
      end
   endtask

   task automatic test_zero(); // R6
      apply('0, '0, 1'b0);
      checks++;
      if (sum !== '0 || cout !== 1'b0) begin
         errors++;
         $display("FAIL R6: got=%h exp=%h", {cout, sum}, 17'h0);
      end
   endtask

   task automatic test_cin_only(); // R7
      apply('0, '0, 1'b1);
      checks++;
      if (sum !== 16'h0001 || cout !== 1'b0) begin
         errors++;
         $display("FAIL R7: got=%h exp=%h", {cout, sum}, 17'h00001);
      end
   endtask

   task automatic test_wrap(); // R4
      apply('1, '1, 1'b1);
      checks++;
      if (sum !== 16'hFFFF || cout !== 1'b1) begin
         errors++;
         $display("FAIL R4: got=%h exp=%h", {cout, sum}, 17'h1FFFF);
      end
      apply('1, '0, 1'b1);
      checks++;
      if (sum !== 16'h0000 || cout !== 1'b1) begin
         errors++;
         $display("FAIL R4: got=%h exp=%h", {cout, sum}, 17'h10000);
      end
   endtask

   task automatic test_boundaries(); // R5 and R3
      int bnd [4] = '{2, 4, 7, 11};
      foreach (bnd[k]) begin
         logic [W-1:0] low;
         low = (16'h1 << bnd[k]) - 16'h1;
         apply(low, '0, 1'b1);          // carry rides in from cin
         check_full("R5");
         apply(16'h1 << (bnd[k] - 1), 16'h1 << (bnd[k] - 1), 1'b0); // carry made at boundary
         check_full("R3");
         apply(low | (16'h1 << bnd[k]) , low, 1'b1); // slice above sees carry plus own bit
         check_full("R3");
      end
   endtask

   task automatic test_patterns(); // R1
      apply(16'hAAAA, 16'h5555, 1'b0); check_full("R1");
      apply(16'hAAAA, 16'h5555, 1'b1); check_full("R1");
      apply(16'hAAAA, 16'hAAAA, 1'b1); check_full("R1");
      apply(16'h5555, 16'h5555, 1'b0); check_full("R1");
      apply(16'h8000, 16'h8000, 1'b0); check_full("R1");
   endtask

   task automatic test_low_slice(); // R2
      for (int v = 0; v < 32; v++) begin
         logic [2:0] exp_low;
         logic [W-1:0] av, bv;
         av = {$urandom()} [W-1:0];
         bv = {$urandom()} [W-1:0];
         av[1:0] = v[1:0];
         bv[1:0] = v[3:2];
         apply(av, bv, v[4]);
         exp_low = {1'b0, v[1:0]} + {1'b0, v[3:2]} + {2'b0, v[4]};
         checks++;
         if (sum[1:0] !== exp_low[1:0]) begin
            errors++;
            $display("FAIL R2: got=%b exp=%b", sum[1:0], exp_low[1:0]);
         end
      end
   endtask

   task automatic test_random(); // R1
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] r;
         r = $urandom();
         apply(r[15:0], r[31:16], $urandom() % 2 == 1);
         check_full("R1");
      end
   endtask

   initial begin
      a = '0; b = '0; cin = 1'b0;
      repeat (2) @(posedge clk);
      test_zero();
      test_cin_only();
      test_wrap();
      test_boundaries();
      test_patterns();
      test_low_slice();
      test_random();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule